// File: doc/BRIEF.md
# Table-Driven Multi-Bit Scrambler

This block whitens a stream of data words by XORing each word with the pseudo-random bit sequence of the 7-bit maximal-length generator x^7 + x^4 + 1. It does not step a feedback register at run time. The whole 127-bit period is laid out as a table of 26-bit segments. Each accepted input word reads the next segment, or the next group of segments when the data path is wider, and is XORed with it. Because 26 and 127 share no factor, a table of exactly 127 segments walks through every phase of the sequence. Reading it with an address that counts modulo 127 gives a continuous keystream with no seam.

The data path is `LANES` segments wide, so 26, 52, 78 bits and so on. A word is consumed only on a cycle where the input strobe is high. Idle cycles leave the sequence position untouched. A synchronous frame-start pulse puts the read position back at the table entry whose first bit is the first bit produced from the configured starting state. Any word accepted in that same cycle is scrambled from that point. The result is registered, so the output strobe follows the input strobe one cycle later.

Top module: `scr_core`

## Requirements
- R1: While reset is held and on the first cycle after release, `out_valid_o` is 0 and `out_data_o` is all zeros. The first word accepted after reset is scrambled from the configured starting state `SEED`, as if a frame start had been given.
- R2: For every accepted word, `out_data_o` equals `in_data_i` XOR a keystream slice. Bit 0 of the slice is the earliest sequence bit and each higher bit is the next bit in time.
- R3: Consecutive accepted words use consecutive, non-overlapping slices of the sequence, continuing across the period. The keystream word sequence therefore repeats exactly every 127 accepted words.
- R4: `out_valid_o` equals `in_valid_i` delayed by one clock cycle.
- R5: A cycle with `in_valid_i` low and `sof_i` low consumes no sequence bits. The next accepted word continues exactly where the previous one stopped.
- R6: When `sof_i` and `in_valid_i` are both high, that word is scrambled starting from `SEED`.
- R7: When `sof_i` is high and `in_valid_i` is low, no output word is produced. The next accepted word, however many idle cycles later, starts from `SEED`.
- R8: While `out_valid_o` is low, `out_data_o` keeps the value of the last produced word.
- R9: The sequence bit is state[6] XOR state[3] of a 7-bit register. After each bit the register shifts left by one and the new bit enters at position 0. This gives a period of 127 bits for any nonzero `SEED`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Frame start: restart the sequence from `SEED` |
| in_valid_i | input | 1 | Input word strobe |
| in_data_i | input | 26*LANES | Plain data word |
| out_valid_o | output | 1 | Output word strobe, one cycle after the input |
| out_data_o | output | 26*LANES | Scrambled data word |

## Verification
The hardest situation to reach is the wrap of the table address from entry 126 back to 0. It lines up with the sequence period only after 127 accepted words with no frame start in between. Gaps of idle cycles must not disturb that count. A directed run feeds all-zero data for 128 words without a restart, with idle gaps inserted. It compares the keystream seen on word 127 against word 0. A long random phase adds frame starts that arrive with and without a word. Each output is compared against a bit-serial model of the generator.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int SEG_W  = 26;
    localparam int PERIOD = 127;
    localparam int GEN_W  = 7;
    localparam int ADDR_W = $clog2(PERIOD + 1);

    localparam logic [GEN_W-1:0] TABLE_BASE = 7'h7F;

    // one generator step: returns the next state; bit 0 of the new state is the emitted bit
    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] st);
        return {st[GEN_W-2:0], st[6] ^ st[3]};
    endfunction

    // full period of the sequence, bit n = n-th emitted bit starting from state st
    function automatic logic [PERIOD-1:0] gen_period(input logic [GEN_W-1:0] st);
        logic [PERIOD-1:0] seq;
        logic [GEN_W-1:0]  s;
        s   = st;
        seq = '0;
        for (int n = 0; n < PERIOD; n++) begin
            seq[n] = s[6] ^ s[3];
            s      = gen_step(s);
        end
        return seq;
    endfunction

    // number of steps from TABLE_BASE until the generator holds seed
    function automatic int seed_phase(input logic [GEN_W-1:0] seed);
        logic [GEN_W-1:0] s;
        int               ph;
        s  = TABLE_BASE;
        ph = 0;
        for (int n = 0; n < PERIOD; n++) begin
            if (s == seed && ph == 0 && n != 0) ph = n;
            s = gen_step(s);
        end
        if (seed == TABLE_BASE) ph = 0;
        return ph;
    endfunction

    // table entry whose first bit sits at sequence phase ph (26 and 127 are coprime)
    function automatic int entry_of_phase(input int ph);
        int k_hit;
        k_hit = 0;
        for (int k = 0; k < PERIOD; k++) begin
            if (((k * SEG_W) % PERIOD) == ph) k_hit = k;
        end
        return k_hit;
    endfunction

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctrl_state_t;

endpackage

// File: rtl/scr_seg_rom.sv
module scr_seg_rom
    import scr_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic [ADDR_W-1:0] rd_addr [LANES],
    output logic [SEG_W-1:0]  rd_word [LANES]
);

    localparam logic [PERIOD-1:0] SEQ     = gen_period(TABLE_BASE);
    localparam int                ENTRIES = 1 << ADDR_W;

    logic [SEG_W-1:0] tbl [ENTRIES];

    // segment k holds sequence bits (26k + j) mod 127, bit j earliest first
    always_comb begin
        for (int k = 0; k < ENTRIES; k++) begin
            for (int j = 0; j < SEG_W; j++) begin
                if (k < PERIOD) tbl[k][j] = SEQ[(k * SEG_W + j) % PERIOD];
                else            tbl[k][j] = 1'b0;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_port
        assign rd_word[l] = tbl[rd_addr[l]];
    end

endmodule

// File: rtl/scr_addr_ctrl.sv
module scr_addr_ctrl
    import scr_pkg::*;
#(
    parameter int               LANES = 1,
    parameter logic [GEN_W-1:0] SEED  = 7'h5D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              take_i,
    output logic [ADDR_W-1:0] lane_addr_o [LANES]
);

    localparam int START      = entry_of_phase(seed_phase(SEED));
    localparam int STEP       = LANES % PERIOD;
    localparam int AFTER_SOF  = (START + STEP) % PERIOD;

    ctrl_state_t st_d, st_q;
    logic [ADDR_W-1:0] eff_addr;

    always_comb begin
        st_d     = st_q;
        eff_addr = sof_i ? ADDR_W'(START) : st_q.addr;
        if (take_i) st_d.addr = ADDR_W'((int'(eff_addr) + STEP) % PERIOD);
        else        st_d.addr = eff_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.addr <= ADDR_W'(START);
        else        st_q      <= st_d;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_addr_o[l] = ADDR_W'((int'(eff_addr) + l) % PERIOD);
    end

    // R3: table position never leaves the 127-entry range
    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.addr) < PERIOD);

    // R3: each accepted word without restart advances by LANES entries modulo 127
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !sof_i) |=> int'(st_q.addr) == (int'($past(st_q.addr)) + STEP) % PERIOD);

    // R5: idle cycles leave the position unchanged
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !sof_i) |=> $stable(st_q.addr));

    // R6: restart with a word consumes the seed entry group
    p_sof_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && take_i) |=> int'(st_q.addr) == AFTER_SOF);

    // R7: restart without a word parks on the seed entry
    p_sof_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !take_i) |=> int'(st_q.addr) == START);

endmodule

// File: rtl/scr_core.sv
module scr_core
    import scr_pkg::*;
#(
    parameter int               LANES = 1,
    parameter logic [GEN_W-1:0] SEED  = 7'h5D,
    localparam int              W     = SEG_W * LANES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sof_i,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_data_i,
    output logic         out_valid_o,
    output logic [W-1:0] out_data_o
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } out_state_t;

    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [SEG_W-1:0]  lane_word [LANES];
    logic [W-1:0]      keystream;
    out_state_t        o_d, o_q;

    scr_addr_ctrl #(.LANES(LANES), .SEED(SEED)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .take_i      (in_valid_i),
        .lane_addr_o (lane_addr)
    );

    scr_seg_rom #(.LANES(LANES)) u_rom (
        .rd_addr (lane_addr),
        .rd_word (lane_word)
    );

    // lane 0 occupies the low bits and carries the earliest sequence bits
    for (genvar l = 0; l < LANES; l++) begin : g_ks
        assign keystream[l*SEG_W +: SEG_W] = lane_word[l];
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = in_valid_i;
        if (in_valid_i) o_d.data = in_data_i ^ keystream;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid_o = o_q.valid;
    assign out_data_o  = o_q.data;

    // R4: strobe appears exactly one cycle after the input strobe
    p_valid_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    p_valid_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    // R8: output word holds while nothing is produced
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(out_data_o));

endmodule

// File: tb/tb_scr_core.sv
`timescale 1ns/1ps
module tb_scr_core;

    localparam int         W    = 26;
    localparam logic [6:0] SEED = 7'h5D;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sof_i, in_valid_i;
    logic [W-1:0] in_data_i;
    logic         out_valid_o;
    logic [W-1:0] out_data_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [6:0]   mst;
    logic         exp_valid;
    logic [W-1:0] exp_data;
    logic [W-1:0] ks_first, ks_last;

    always #4 clk = ~clk;

    scr_core #(.LANES(1), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
    );

    // bit-serial reference generator (R9)
    function automatic logic [W-1:0] model_word();
        logic [W-1:0] w;
        logic         b;
        for (int j = 0; j < W; j++) begin
            b    = mst[6] ^ mst[3];
            w[j] = b;
            mst  = {mst[5:0], b};
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input logic sof, input logic vld, input logic [W-1:0] din,
                        input string dreq);
        sof_i      = sof;
        in_valid_i = vld;
        in_data_i  = din;
        if (sof) mst = SEED;
        exp_valid = vld;
        if (vld) exp_data = din ^ model_word();
        @(posedge clk);
        @(negedge clk);
        check("R4 valid", {25'd0, out_valid_o}, {25'd0, exp_valid});
        check(vld ? dreq : "R8 hold", out_data_o, exp_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; sof_i = 0; in_valid_i = 0; in_data_i = '0;
        mst = SEED; exp_valid = 0; exp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {25'd0, out_valid_o}, 26'd0);
        check("R1 reset data", out_data_o, '0);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        check("R1 first cycle valid", {25'd0, out_valid_o}, 26'd0);

        // R1/R2: first word after reset exposes the keystream from SEED
        step(0, 1, '0, "R1 first word from seed");
        step(0, 1, 26'h3FFFFFF, "R2 all-ones data");
        // R5: idle gap, then continuation
        repeat (5) step(0, 0, 26'h1234567, "R5");
        step(0, 1, 26'h2AAAAAA, "R5 continue after idle");
        // R6: restart together with a word
        step(1, 1, '0, "R6 sof with word");
        step(0, 1, 26'h0F0F0F0, "R6 after restart");
        // R7: restart alone, idle, then word
        step(1, 0, 26'h3333333, "R7");
        repeat (3) step(0, 0, '0, "R7");
        step(0, 1, '0, "R7 first word after lone sof");

        // R3: 128 zero words with gaps, no restart; keystream must repeat after 127
        step(1, 1, '0, "R3 wrap run");
        ks_first = out_data_o;
        for (int i = 1; i < 128; i++) begin
            if (i % 17 == 0) step(0, 0, '0, "R3");
            step(0, 1, '0, "R3 wrap run");
            if (i == 127) ks_last = out_data_o;
        end
        check("R3 period of 127 words", ks_last, ks_first);

        // random traffic
        for (int i = 0; i < 1500; i++) begin
            logic s, v;
            s = ($urandom_range(0, 99) < 3);
            v = ($urandom_range(0, 99) < 70);
            step(s, v, W'($urandom), "R2 random");
        end

        done = 1;
        summary();
    end

endmodule